// File: doc/BRIEF.md
# Byte-Lane Memory with Misaligned Access Sequencing

This block is a RAM built from 64-bit words that serves byte, halfword, word and doubleword loads and stores at any byte address, little-endian. A requester drives one request (address, size code, write enable, write data) and holds it until the block answers with a one-cycle completion pulse, read data and an error flag.

An access that fits inside one word at its natural alignment uses one array access with byte-lane masking. A doubleword on a 4-byte but not 8-byte boundary is split into two word accesses. Every other misaligned access is split into single bytes in ascending address order and reassembled. A range decoder maps a fixed physical base onto the array and flags addresses that fall outside it.

Top module: `mlane_mem`

## Requirements
- R1: After reset, done_o, err_o and rdata_o are 0 and every RAM byte reads as 0.
- R2: size_i encodes 00 byte, 01 halfword, 10 word, 11 doubleword. Byte i of the access is byte address addr+i and sits at rdata_o/wdata_i bits [8i+7:8i]. Read data is zero-extended to 64 bits.
- R3: An access whose address is a multiple of its own size completes in one array access, so done_o rises 1 clock edge after the request is first sampled.
- R4: A write changes only the bytes it addresses. All other bytes of the word keep their value.
- R5: A doubleword at an address that is a multiple of 4 but not of 8 is done as two word accesses (addr, then addr+4), so done_o rises on the 2nd edge.
- R6: Any other misaligned access is done one byte per cycle in ascending address order, including across word boundaries, so done_o rises on edge N where N is the access size in bytes.
- R7: Address BASE (0x80000000) is RAM byte 0, and the RAM offset is the address minus BASE.
- R8: An access below BASE, or one whose last byte is at or past the RAM end, completes on the 1st edge with err_o=1 and rdata_o=0, and a write of that kind leaves the RAM unchanged.
- R9: done_o is high for exactly one cycle. No new access starts in that cycle, even if req_i stays high.
- R10: The RAM holds CAP_BYTES rounded up to a whole number of 8-byte words, and the range check uses that rounded size. With CAP_BYTES=250 the RAM spans offsets 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid, held until done_o |
| addr_i | input | ADDR_W | Physical byte address |
| size_i | input | 2 | Access size code |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 64 | Write data, byte 0 in bits [7:0] |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Read data, valid with done_o |
| err_o | output | 1 | Out-of-range flag, valid with done_o |

## Verification
Each result has a fixed due edge. Aligned and out-of-range accesses are due on the 1st edge after the request. A 4-aligned doubleword is due on the 2nd edge. A byte-split access is due on the edge equal to its byte count. A monitor samples 1 ns after each rising edge and counts the sampled edges during which the request was held. When done_o is seen, it compares that count, err_o and rdata_o with the head of a queue that the driver filled from a byte-array model. It also confirms that done_o falls at the next sample.

// File: rtl/mlane_pkg.sv
package mlane_pkg;
  typedef enum logic [1:0] {SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10, SZ_D = 2'b11} size_e;
  typedef enum logic [1:0] {SPLIT_ONE, SPLIT_HALVES, SPLIT_BYTES} split_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/mlane_range.sv
module mlane_range #(
  parameter int unsigned       ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h8000_0000,
  parameter int unsigned       LIMIT  = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] off_o,
  output logic              err_o
);
  import mlane_pkg::*;
  localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LIMIT);

  logic [ADDR_W:0] end_x;

  always_comb begin
    off_o = addr_i - BASE;
    end_x = {1'b0, off_o} + (ADDR_W+1)'(size_bytes(size_i));
    err_o = (addr_i < BASE) || (end_x > LIM);
  end
endmodule

// File: rtl/mlane_lane.sv
module mlane_lane (
  input  logic [2:0]  lane_i,
  input  logic [1:0]  size_i,
  input  logic [63:0] word_i,
  input  logic [63:0] data_i,
  output logic [7:0]  mask_o,
  output logic [63:0] wword_o,
  output logic [63:0] piece_o
);
  import mlane_pkg::*;

  logic [8:0]  base_m;
  logic [63:0] full_m;

  assign base_m = (9'd1 << size_bytes(size_i)) - 9'd1;

  for (genvar b = 0; b < 8; b++) begin : g_expand
    assign full_m[8*b +: 8] = {8{base_m[b]}};
  end

  assign mask_o  = base_m[7:0] << lane_i;
  assign wword_o = data_i << {lane_i, 3'b000};
  assign piece_o = (word_i >> {lane_i, 3'b000}) & full_m;
endmodule

// File: rtl/mlane_seq.sv
module mlane_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] off_lo_i,
  input  logic [1:0] size_i,
  input  logic       err_i,
  output logic       go_o,
  output logic       first_o,
  output logic       last_o,
  output logic [2:0] pos_o,
  output logic [1:0] sub_size_o,
  output logic       done_o
);
  import mlane_pkg::*;

  split_e     mode;
  logic [3:0] nbytes;
  logic [3:0] nsteps;
  logic [3:0] cnt_q;
  logic       done_q;
  logic       aligned;

  always_comb begin
    nbytes  = size_bytes(size_i);
    aligned = (off_lo_i & 3'(nbytes - 4'd1)) == 3'd0;
    if (err_i || aligned)                              mode = SPLIT_ONE;
    else if (size_i == SZ_D && off_lo_i[1:0] == 2'b00) mode = SPLIT_HALVES;
    else                                               mode = SPLIT_BYTES;
    unique case (mode)
      SPLIT_ONE:    begin nsteps = 4'd1; pos_o = 3'd0;            sub_size_o = size_i; end
      SPLIT_HALVES: begin nsteps = 4'd2; pos_o = {cnt_q[0], 2'b00}; sub_size_o = SZ_W; end
      default:      begin nsteps = nbytes; pos_o = cnt_q[2:0];     sub_size_o = SZ_B;   end
    endcase
  end

  assign go_o    = req_i && !done_q;
  assign first_o = cnt_q == 4'd0;
  assign last_o  = go_o && (cnt_q == nsteps - 4'd1);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (last_o)    cnt_q <= '0;
      else if (go_o) cnt_q <= cnt_q + 4'd1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (cnt_q < nsteps));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_halves_two_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && mode == SPLIT_HALVES && !first_o) |-> last_o);
endmodule

// File: rtl/mlane_mem.sv
module mlane_mem #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE      = 32'h8000_0000,
  parameter int unsigned       CAP_BYTES = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [63:0]       wdata_i,
  output logic              done_o,
  output logic [63:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned DEPTH = (CAP_BYTES + 7) / 8;
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LIMIT = DEPTH * 8;

  logic [DEPTH-1:0][63:0] mem_q;
  logic [ADDR_W-1:0]      off, sub_off;
  logic [ADDR_W-4:0]      idx;
  logic [IDX_W-1:0]       widx;
  logic                   idx_ok, rng_err;
  logic                   go, first, last;
  logic [2:0]             pos;
  logic [1:0]             sub_size;
  logic [63:0]            rword, chunk, wword, piece, acc_q, acc_d;
  logic [7:0]             mask;
  logic                   err_q, wr_en;

  mlane_range #(.ADDR_W(ADDR_W), .BASE(BASE), .LIMIT(LIMIT)) u_range (
    .addr_i(addr_i), .size_i(size_i), .off_o(off), .err_o(rng_err)
  );

  mlane_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .off_lo_i(off[2:0]),
    .size_i(size_i), .err_i(rng_err), .go_o(go), .first_o(first),
    .last_o(last), .pos_o(pos), .sub_size_o(sub_size), .done_o(done_o)
  );

  always_comb begin
    sub_off = off + ADDR_W'(pos);
    idx     = sub_off[ADDR_W-1:3];
    widx    = idx[IDX_W-1:0];
    idx_ok  = idx < (ADDR_W-3)'(DEPTH);
    rword   = idx_ok ? mem_q[widx] : 64'd0;
    chunk   = wdata_i >> {pos, 3'b000};
  end

  mlane_lane u_lane (
    .lane_i(sub_off[2:0]), .size_i(sub_size), .word_i(rword), .data_i(chunk),
    .mask_o(mask), .wword_o(wword), .piece_o(piece)
  );

  assign acc_d = (first ? 64'd0 : acc_q) | ((rng_err ? 64'd0 : piece) << {pos, 3'b000});
  assign wr_en = go && we_i && !rng_err && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= last && rng_err;
      if (go) acc_q <= acc_d;
      if (wr_en) begin
        for (int b = 0; b < 8; b++) begin
          if (mask[b]) mem_q[widx][8*b +: 8] <= wword[8*b +: 8];
        end
      end
    end
  end

  assign rdata_o = acc_q;
  assign err_o   = err_q;

  p_err_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && rng_err) |=> $stable(mem_q));
  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == 64'd0));
  p_lane_fit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !rng_err) |-> ({1'b0, sub_off[2:0]} + mlane_pkg::size_bytes(sub_size) <= 4'd8));
  p_err_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

// File: tb/mlane_mem_tb.sv
`timescale 1ns/1ps
module mlane_mem_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int          RAM  = 256;

  typedef struct {
    logic [63:0] rd;
    logic        chk_rd;
    logic        err;
    int          lat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic        done, err;
  logic [63:0] rdata;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t q[$];
  logic [7:0] model [RAM];
  int   lat_cnt = 0;
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  mlane_mem dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .size_i(size),
    .we_i(we), .wdata_i(wdata), .done_o(done), .rdata_o(rdata), .err_o(err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R9 done pulse", 64'(done && prev_done), 64'd0);
      if (req) lat_cnt++;
      if (done) begin
        if (q.size() == 0) begin
          check("unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " latency"}, 64'(lat_cnt), 64'(e.lat));
          check({e.tag, " err"}, 64'(err), 64'(e.err));
          if (e.chk_rd) check({e.tag, " rdata"}, rdata, e.rd);
        end
        lat_cnt = 0;
      end
      prev_done = done;
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic w,
                        input logic [63:0] d, input string tag);
    exp_t        e;
    int          nb;
    logic [31:0] off;
    logic [32:0] endx;
    nb   = 1 << s;
    off  = a - BASE;
    endx = {1'b0, off} + 33'(nb);
    e.err = (a < BASE) || (endx > 33'(RAM));
    if (e.err)                           e.lat = 1;
    else if (off % nb == 0)              e.lat = 1;
    else if (s == 2'b11 && off % 4 == 0) e.lat = 2;
    else                                 e.lat = nb;
    e.rd = '0;
    if (!e.err && !w)
      for (int i = 0; i < nb; i++) e.rd[8*i +: 8] = model[off + i];
    e.chk_rd = !w || e.err;
    e.tag    = tag;
    if (!e.err && w)
      for (int i = 0; i < nb; i++) model[off + i] = d[8*i +: 8];
    q.push_back(e);
    @(negedge clk);
    addr = a; size = s; we = w; wdata = d; req = 1'b1;
    forever begin
      @(negedge clk);
      if (done) break;
    end
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < RAM; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 done reset", 64'(done), 64'd0);
    check("R1 err reset", 64'(err), 64'd0);
    check("R1 rdata reset", rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    access(BASE + 32'h10, 2'b11, 1'b0, '0, "R1 zero ram");
    access(BASE, 2'b11, 1'b1, 64'h1122_3344_5566_7788, "R3 aligned dword write");
    access(BASE + 32'h1, 2'b00, 1'b0, '0, "R2 byte read");
    access(BASE + 32'h2, 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_BEEF, "R4 half write");
    access(BASE, 2'b11, 1'b0, '0, "R4 merged dword");
    access(BASE + 32'h4, 2'b10, 1'b0, '0, "R2 word zero-ext");
    access(BASE + 32'h24, 2'b11, 1'b1, 64'hA1A2_A3A4_B1B2_B3B4, "R5 split dword write");
    access(BASE + 32'h24, 2'b11, 1'b0, '0, "R5 split dword read");
    access(BASE + 32'h28, 2'b10, 1'b0, '0, "R5 high word");
    access(BASE + 32'h20, 2'b11, 1'b0, '0, "R7 low part");
    access(BASE + 32'h7, 2'b10, 1'b1, 64'h0000_0000_C0DE_F00D, "R6 cross word write");
    access(BASE, 2'b11, 1'b0, '0, "R6 word0 after");
    access(BASE + 32'h8, 2'b11, 1'b0, '0, "R6 word1 after");
    access(BASE + 32'h3F, 2'b01, 1'b1, 64'h0000_0000_0000_5A69, "R6 half cross");
    access(BASE + 32'h3F, 2'b01, 1'b0, '0, "R6 half read");
    access(BASE + 32'h13, 2'b11, 1'b1, 64'h0102_0304_0506_0708, "R6 byte dword");
    access(BASE + 32'h13, 2'b11, 1'b0, '0, "R6 byte dword read");
    access(32'h7FFF_FFF8, 2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8 below base write");
    access(32'h7FFF_FFFC, 2'b10, 1'b0, '0, "R8 below base read");
    access(BASE + 32'hF8, 2'b11, 1'b0, '0, "R8 ram untouched");
    access(BASE + 32'hFC, 2'b10, 1'b1, 64'h0000_0000_DEAD_BEEF, "R10 rounded tail write");
    access(BASE + 32'hFC, 2'b10, 1'b0, '0, "R10 rounded tail read");
    access(BASE + 32'hFC, 2'b11, 1'b1, 64'h1111_2222_3333_4444, "R8 past end write");
    access(BASE + 32'h100, 2'b00, 1'b0, '0, "R10 end read");
    access(BASE + 32'hF8, 2'b11, 1'b0, '0, "R8 tail unchanged");
    access(BASE + 32'h40, 2'b00, 1'b1, 64'h0000_0000_0000_00EE, "R2 byte write");
    access(BASE + 32'h40, 2'b11, 1'b0, '0, "R4 byte only");
    repeat (3) @(negedge clk);
    check("R9 queue drained", 64'(q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule